// File: doc/BRIEF.md
# Security Violation Capture and Interrupt Unit

This unit collects one-cycle violation pulses raised by the checkers in front of protected targets. Those targets include the two peripheral buses, GPIO, the external memory bus, USB host, CRC, SD host, the two DMA engines, two SRAM banks, the flash controller, flash data, the security controller, the system manager and the crypto engine. For every target it keeps a sticky status flag. It also records which bus master made the offending access and which target address that access used.

That record is frozen from the first violation until software clears the flag for that source. The first offender is therefore never lost to a later one. A single interrupt line is raised when any flagged source also has its enable bit set.

Software reaches the unit through a simple word register port. Reads are combinational and writes take effect on the clock edge. The checkers that detect violations are outside this block.

Top module: `sec_viol_capture`

## Requirements
- R1: After reset the enable word, the status word and every captured master ID and address read as zero, and `irq` is low.
- R2: A pulse on an implemented source whose flag is clear sets that flag. In the same edge it also stores that source's 4-bit master ID and 32-bit address. All of these are readable from the cycle after the pulse.
- R3: While a source's flag is set, further pulses on that source leave its stored master ID and address unchanged.
- R4: Writing the status word (offset 0x30) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. After a clear, the next pulse on that source captures fresh data.
- R5: If a pulse and a clearing write hit the same source on the same edge, the flag stays set and the stored data is that of the new pulse.
- R6: `irq` is the OR over sources of (flag AND enable), where the enable word is at offset 0x2C. A flag sets whether or not its enable bit is 1, and `irq` follows changes of either word.
- R7: Bit positions with no source are 2, 3 and 9; the implemented mask is 0x7FDF3. These positions read 0 in the enable and status words whatever is written, pulses on them set nothing, and their capture registers read 0.
- R8: Status and enable bit n both belong to the source on pulse input n. The master ID of source n reads at offset 0x34 + 8·n in bits [3:0], with bits [31:4] zero, and its address reads at 0x38 + 8·n.
- R9: Pulses on several sources in the same cycle each set their own flag and capture their own master ID and address.
- R10: Writes to capture registers have no effect on the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| viol_pulse | input | 19 | Per-source violation pulse, bit n = source n |
| viol_mid | input | 76 | Per-source master ID, 4 bits per source |
| viol_addr | input | 608 | Per-source violating address, 32 bits per source |
| irq | output | 1 | Combined violation interrupt |

## Verification
The bench builds the unit with its default parameters: 19 bit slots, the 0x7FDF3 implemented mask and a 4-bit master ID. Every hole position and both edge slots 0 and 18 can therefore be driven and read back. The directed cases cover the first-capture freeze against a second offender and a clear-and-pulse collision on one source. They also cover simultaneous pulses on the lowest and highest slots and enable gating of the interrupt in both directions. A master ID of 0xF confirms that the upper bits of the ID word stay zero.

// File: rtl/sec_viol_capture.sv
module sec_viol_capture #(
  parameter int NUM_SLOT = 19,
  parameter logic [NUM_SLOT-1:0] SRC_MASK = 19'h7FDF3,
  parameter int MID_W    = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int REG_AW   = 12,
  parameter int EN_OFS   = 'h02C,
  parameter int STS_OFS  = 'h030,
  parameter int CAP_BASE = 'h034
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [REG_AW-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  input  logic [NUM_SLOT-1:0]        viol_pulse,
  input  logic [NUM_SLOT*MID_W-1:0]  viol_mid,
  input  logic [NUM_SLOT*ADDR_W-1:0] viol_addr,
  output logic                       irq
);

  localparam int CAP_STEP = 8;
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(SRC_MASK);

  logic [DATA_W-1:0] en_q, sts_q;
  logic [MID_W-1:0]  mid_q [NUM_SLOT];
  logic [ADDR_W-1:0] adr_q [NUM_SLOT];

  wire en_hit  = cfg_we && (cfg_addr == REG_AW'(EN_OFS));
  wire sts_hit = cfg_we && (cfg_addr == REG_AW'(STS_OFS));

  wire [DATA_W-1:0] clr  = sts_hit ? (cfg_wdata & MASK_W) : '0;
  wire [DATA_W-1:0] set  = DATA_W'(viol_pulse) & MASK_W;
  wire [DATA_W-1:0] load = set & (~sts_q | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_hit) en_q <= cfg_wdata & MASK_W;
      sts_q <= (sts_q & ~clr) | set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOT; i++) begin
        mid_q[i] <= '0;
        adr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOT; i++) begin
        if (load[i]) begin
          mid_q[i] <= viol_mid[i*MID_W +: MID_W];
          adr_q[i] <= viol_addr[i*ADDR_W +: ADDR_W];
        end
      end
    end
  end

  assign irq = |(en_q & sts_q);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == REG_AW'(EN_OFS))  cfg_rdata = en_q;
    if (cfg_addr == REG_AW'(STS_OFS)) cfg_rdata = sts_q;
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (cfg_addr == REG_AW'(CAP_BASE + CAP_STEP*i))
        cfg_rdata = DATA_W'(mid_q[i]);
      if (cfg_addr == REG_AW'(CAP_BASE + CAP_STEP*i + 4))
        cfg_rdata = DATA_W'(adr_q[i]);
    end
  end

endmodule

// File: rtl/sec_viol_capture_chk.sv
module sec_viol_capture_chk #(
  parameter int NUM_SLOT = 19,
  parameter logic [NUM_SLOT-1:0] SRC_MASK = 19'h7FDF3,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int REG_AW   = 12,
  parameter int STS_OFS  = 'h030
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [REG_AW-1:0]   cfg_addr,
  input logic [DATA_W-1:0]   cfg_wdata,
  input logic [NUM_SLOT-1:0] viol_pulse,
  input logic                irq,
  input logic [DATA_W-1:0]   en_q,
  input logic [DATA_W-1:0]   sts_q,
  input logic [ADDR_W-1:0]   adr_q [NUM_SLOT]
);

  wire sts_wr = cfg_we && (cfg_addr == REG_AW'(STS_OFS));

  a_r6_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    if (SRC_MASK[g]) begin : g_impl
      a_r2_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse[g] |=> sts_q[g]);
      a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && cfg_wdata[g] && !viol_pulse[g]) |=> !sts_q[g]);
      a_r3_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[g] && !(sts_wr && cfg_wdata[g])) |=> $stable(adr_q[g]));
    end else begin : g_hole
      a_r7_hole_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse[g] |=> !sts_q[g]);
    end
  end

endmodule

bind sec_viol_capture sec_viol_capture_chk #(
  .NUM_SLOT(NUM_SLOT), .SRC_MASK(SRC_MASK), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .REG_AW(REG_AW), .STS_OFS(STS_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .viol_pulse(viol_pulse), .irq(irq),
  .en_q(en_q), .sts_q(sts_q), .adr_q(adr_q)
);

// File: tb/sec_viol_capture_tb_top.sv
module sec_viol_capture_tb_top;
  localparam int NS = 19, MW = 4, AW = 32;
  localparam logic [31:0] EN = 32'h2C, STS = 32'h30, MASK = 32'h7FDF3;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NS-1:0] viol_pulse = '0;
  logic [NS*MW-1:0] viol_mid = '0;
  logic [NS*AW-1:0] viol_addr = '0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sec_viol_capture dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .viol_pulse(viol_pulse),
    .viol_mid(viol_mid), .viol_addr(viol_addr), .irq(irq));

  function automatic logic [11:0] mid_ofs(int n); return 12'(32'h34 + 8*n); endfunction
  function automatic logic [11:0] adr_ofs(int n); return 12'(32'h38 + 8*n); endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); cfg_we = 0; cfg_addr = a; #1 v = cfg_rdata;
  endtask

  task automatic rchk(string rq, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); chk(rq, v, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load_src(int n, logic [3:0] m, logic [31:0] a);
    viol_pulse[n] = 1; viol_mid[n*MW +: MW] = m; viol_addr[n*AW +: AW] = a;
  endtask

  task automatic pulse(int n, logic [3:0] m, logic [31:0] a);
    @(negedge clk); load_src(n, m, a);
    @(negedge clk); viol_pulse = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    rchk("R1 enable", EN, 0);
    rchk("R1 status", STS, 0);
    rchk("R1 mid0", mid_ofs(0), 0);
    rchk("R1 adr18", adr_ofs(18), 0);
  endtask

  task automatic t_capture;
    pulse(5, 4'd3, 32'h4000_1234);
    rchk("R2 status", STS, 32'h20);
    rchk("R2 mid", mid_ofs(5), 3);
    rchk("R2 adr", adr_ofs(5), 32'h4000_1234);
    chk("R6 flag without enable no irq", 32'(irq), 0);
  endtask

  task automatic t_frozen;
    pulse(5, 4'd11, 32'h5555_AAAA);
    rchk("R3 mid", mid_ofs(5), 3);
    rchk("R3 adr", adr_ofs(5), 32'h4000_1234);
  endtask

  task automatic t_irq;
    wr(EN, 32'h1);
    chk("R6 other enable", 32'(irq), 0);
    wr(EN, 32'h20);
    chk("R6 irq on", 32'(irq), 1);
    wr(EN, 0);
    chk("R6 irq off", 32'(irq), 0);
  endtask

  task automatic t_clear;
    wr(STS, 32'hFFFF_FFDF);
    rchk("R4 write0 keeps", STS, 32'h20);
    wr(STS, 32'h20);
    rchk("R4 cleared", STS, 0);
    pulse(5, 4'd6, 32'h2000_0040);
    rchk("R4 recapture mid", mid_ofs(5), 6);
    rchk("R4 recapture adr", adr_ofs(5), 32'h2000_0040);
  endtask

  task automatic t_race;
    @(negedge clk);
    cfg_we = 1; cfg_addr = STS; cfg_wdata = 32'h20;
    load_src(5, 4'd4, 32'h6000_0010);
    @(negedge clk); cfg_we = 0; viol_pulse = '0;
    rchk("R5 flag kept", STS, 32'h20);
    rchk("R5 new mid", mid_ofs(5), 4);
    rchk("R5 new adr", adr_ofs(5), 32'h6000_0010);
    wr(STS, 32'h20);
  endtask

  task automatic t_holes;
    @(negedge clk); load_src(2, 4'd5, 32'h1); load_src(3, 4'd5, 32'h2); load_src(9, 4'd5, 32'h3);
    @(negedge clk); viol_pulse = '0;
    rchk("R7 status holes", STS, 0);
    rchk("R7 hole mid", mid_ofs(9), 0);
    rchk("R7 hole adr", adr_ofs(3), 0);
    wr(EN, 32'hFFFF_FFFF);
    rchk("R7 enable mask", EN, MASK);
    wr(EN, 0);
  endtask

  task automatic t_multi;
    @(negedge clk); load_src(0, 4'hF, 32'hDEAD_0000); load_src(18, 4'd0, 32'h0000_BEEF);
    @(negedge clk); viol_pulse = '0;
    rchk("R9 status", STS, 32'h4_0001);
    rchk("R8 mid0 upper zero", mid_ofs(0), 32'hF);
    rchk("R9 adr0", adr_ofs(0), 32'hDEAD_0000);
    rchk("R9 mid18", mid_ofs(18), 0);
    rchk("R9 adr18", adr_ofs(18), 32'h0000_BEEF);
    wr(EN, 32'h4_0000);
    chk("R8 enable bit18 irq", 32'(irq), 1);
    wr(EN, 0);
  endtask

  task automatic t_ro;
    wr(adr_ofs(0), 32'h1111_2222);
    wr(mid_ofs(0), 32'h3);
    rchk("R10 adr0 kept", adr_ofs(0), 32'hDEAD_0000);
    rchk("R10 mid0 kept", mid_ofs(0), 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_capture(); t_frozen(); t_irq(); t_clear();
    t_race(); t_holes(); t_multi(); t_ro();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule